// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a TFT panel. Software programs the horizontal and vertical timing, the sync polarities and a control word through a small memory-mapped register port. The block then counts pixel clocks within a line and lines within a frame. From those counts it drives horizontal sync, vertical sync, a data-enable, the current active column and row, and a one-cycle start-of-frame strobe.

Timing values are packed into register fields, and each field is decoded in hardware. Every porch and sync field holds its duration minus one. Active width is held in units of sixteen pixels, minus one. Active height is held in lines, minus one.

The raster runs only while both the enable bit and the panel-power bit are set. Power can only be switched on by a second write, made after enable is already set. Timing registers are frozen while enable is set. Once per frame a status bit records the start of vertical back porch. That bit can be masked onto an interrupt output and is cleared by a write-one-to-clear register. Eight fixed identification bytes sit at the top of the register space.

Top module: `lcd_raster_timing`

## Requirements
- R1: Reads of byte offsets 0xFE0, 0xFE4, 0xFE8, 0xFEC, 0xFF0, 0xFF4, 0xFF8 and 0xFFC return 0x11, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1 in that order. Writes to these offsets change nothing.
- R2: After reset, every register reads as zero. These are the horizontal timing register (0x000), the vertical timing register (0x004), the polarity register (0x008), the spare timing register (0x00C), the control register (0x018), the interrupt mask (0x01C, bits 4:0), raw status (0x020), masked status (0x024) and the clear register (0x028). The timing registers, spare register and mask read back what was written. Raw status and masked status ignore writes. The clear register always reads zero.
- R3: A write to 0x000, 0x004, 0x008 or 0x00C is ignored while the control enable bit (bit 0) is set.
- R4: A control write stores enable from bit 0. It stores power (bit 11) only if enable was already set before the write and bit 0 of the write is also 1. Otherwise power is stored as 0.
- R5: Horizontal fields are sync width at bits 15:8, back porch at 31:24 and front porch at 23:16, each giving a duration of field+1 pixel clocks. Active width is at bits 7:2 and gives (field+1)*16 pixels. A line runs sync, then back porch, then active, then front porch.
- R6: Vertical fields are sync width at bits 15:10, back porch at 31:24 and front porch at 23:16, each giving field+1 lines. Active height is at bits 9:0 and gives field+1 lines. The line count advances after the last front-porch clock of each line, and a frame runs in the same four-phase order.
- R7: Data-enable is high only when both the horizontal and the vertical phase are active. There, the column and row outputs give the zero-based pixel and line index. Both are zero whenever data-enable is low.
- R8: The start-of-frame strobe is high for exactly the one cycle carrying column 0 of row 0.
- R9: Before polarity, sync is high during its sync phase. Polarity register bit 12 inverts horizontal sync and bit 11 inverts vertical sync. Bit 13 is presented unchanged on the pixel-clock-invert output.
- R10: While enable or power is clear, both syncs sit at their inactive level after inversion, data-enable and the strobe are low, and column and row are zero. The first cycle after the write that starts the raster is the first sync clock of line 0.
- R11: Raw status bit 3 is set in the first clock of vertical back porch. Writing 1 to bit 3 of 0x028 clears it, and a set in the same cycle wins. Masked status is raw AND mask, and the interrupt output is high when any masked bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, same cycle |
| lcd_hsync | output | 1 | Horizontal sync after polarity |
| lcd_vsync | output | 1 | Vertical sync after polarity |
| lcd_de | output | 1 | Data-enable |
| lcd_col | output | 12 | Active column index |
| lcd_row | output | 12 | Active row index |
| lcd_sof | output | 1 | Start-of-frame strobe |
| lcd_clk_inv | output | 1 | Pixel-clock inversion select |
| lcd_irq | output | 1 | Interrupt, OR of masked status |

## Verification
Read data is combinational, so each read is sampled one nanosecond after the address is driven on a falling edge, within the same cycle. A register write takes effect at the next rising edge. The raster's first sync clock is therefore the cycle that begins at the edge which stores the power bit. The bench counts cycles from that edge and compares every raster output at each following falling edge against a position computed from the programmed durations. The raw status bit and the interrupt are due one cycle after the last vertical sync clock, which is cycle H*Vs. Here H is the line length and Vs is the number of sync lines. The bench checks each of them at that exact cycle and not before.

// File: rtl/lrt_pkg.sv
// Package: shared types, register offsets and the fixed identification bytes
// for the raster timing generator. Assumes 32-bit registers on word offsets.
package lrt_pkg;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_BACK = 2'd1,
        PH_ACT  = 2'd2,
        PH_FRNT = 2'd3
    } lrt_phase_e;

    // Word offsets (byte offset / 4)
    localparam logic [9:0] W_HTIM  = 10'h000;
    localparam logic [9:0] W_VTIM  = 10'h001;
    localparam logic [9:0] W_POL   = 10'h002;
    localparam logic [9:0] W_SPARE = 10'h003;
    localparam logic [9:0] W_CTRL  = 10'h006;
    localparam logic [9:0] W_MASK  = 10'h007;
    localparam logic [9:0] W_RAW   = 10'h008;
    localparam logic [9:0] W_MSTAT = 10'h009;
    localparam logic [9:0] W_CLR   = 10'h00A;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_PWR_BIT = 11;
    localparam int FRAME_STAT_BIT = 3;
    localparam int STAT_W = 5;

    // Identification byte for a word offset in the top eight words; zero elsewhere.
    function automatic logic [7:0] id_byte(input logic [9:0] word);
        case (word)
            10'h3F8: id_byte = 8'h11;
            10'h3F9: id_byte = 8'h11;
            10'h3FA: id_byte = 8'h04;
            10'h3FB: id_byte = 8'h00;
            10'h3FC: id_byte = 8'h0D;
            10'h3FD: id_byte = 8'hF0;
            10'h3FE: id_byte = 8'h05;
            10'h3FF: id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction

    function automatic logic is_id_word(input logic [9:0] word);
        is_id_word = (word[9:3] == 7'h7F);
    endfunction

endpackage

// File: rtl/lrt_regfile.sv
// Module: lrt_regfile
// Holds the timing, polarity, control, mask and status registers and serves
// combinational reads. Timing writes are dropped while enable is set; power is
// only accepted on top of an already-set enable. Assumes word-aligned offsets.
module lrt_regfile
    import lrt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              frame_evt,
    output logic [7:0]        h_sync_f,
    output logic [7:0]        h_back_f,
    output logic [7:0]        h_frnt_f,
    output logic [5:0]        h_act_f,
    output logic [5:0]        v_sync_f,
    output logic [7:0]        v_back_f,
    output logic [7:0]        v_frnt_f,
    output logic [9:0]        v_act_f,
    output logic              inv_h,
    output logic              inv_v,
    output logic              inv_clk,
    output logic              en,
    output logic              pwr,
    output logic              irq,
    output logic              frame_stat
);
    localparam int WORD_W = ADDR_W - 2;

    logic [DATA_W-1:0] htim_q, vtim_q, pol_q, spare_q, ctrl_q;
    logic [STAT_W-1:0] mask_q, raw_q, clr_v, set_v;
    logic [9:0]        word;
    logic              wr_tim;
    logic              unused_lo;

    assign word      = 10'(addr[ADDR_W-1:2]);
    assign unused_lo = ^addr[1:0];
    assign wr_tim    = wr && !ctrl_q[CTRL_EN_BIT];

    // Timing registers: written only while the controller is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htim_q  <= '0;
            vtim_q  <= '0;
            pol_q   <= '0;
            spare_q <= '0;
        end else if (wr_tim) begin
            if (word == W_HTIM)  htim_q  <= wdata;
            if (word == W_VTIM)  vtim_q  <= wdata;
            if (word == W_POL)   pol_q   <= wdata;
            if (word == W_SPARE) spare_q <= wdata;
        end
    end

    // Control register: power accepted only when enable was set beforehand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr && word == W_CTRL) begin
            ctrl_q <= wdata;
            ctrl_q[CTRL_PWR_BIT] <= wdata[CTRL_PWR_BIT] && wdata[CTRL_EN_BIT]
                                    && ctrl_q[CTRL_EN_BIT];
        end
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr && word == W_MASK)
            mask_q <= wdata[STAT_W-1:0];
    end

    // Raw status set/clear decode; a set in the same cycle wins over a clear.
    always_comb begin
        clr_v = (wr && word == W_CLR) ? wdata[STAT_W-1:0] : '0;
        set_v = '0;
        set_v[FRAME_STAT_BIT] = frame_evt;
    end

    // Raw status register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else
            raw_q <= (raw_q & ~clr_v) | set_v;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (is_id_word(word)) begin
            rdata = DATA_W'(id_byte(word));
        end else begin
            case (word)
                W_HTIM:  rdata = htim_q;
                W_VTIM:  rdata = vtim_q;
                W_POL:   rdata = pol_q;
                W_SPARE: rdata = spare_q;
                W_CTRL:  rdata = ctrl_q;
                W_MASK:  rdata = DATA_W'(mask_q);
                W_RAW:   rdata = DATA_W'(raw_q);
                W_MSTAT: rdata = DATA_W'(raw_q & mask_q);
                default: rdata = '0;
            endcase
        end
    end

    assign h_back_f   = htim_q[31:24];
    assign h_frnt_f   = htim_q[23:16];
    assign h_sync_f   = htim_q[15:8];
    assign h_act_f    = htim_q[7:2];
    assign v_back_f   = vtim_q[31:24];
    assign v_frnt_f   = vtim_q[23:16];
    assign v_sync_f   = vtim_q[15:10];
    assign v_act_f    = vtim_q[9:0];
    assign inv_clk    = pol_q[13];
    assign inv_h      = pol_q[12];
    assign inv_v      = pol_q[11];
    assign en         = ctrl_q[CTRL_EN_BIT];
    assign pwr        = ctrl_q[CTRL_PWR_BIT];
    assign irq        = |(raw_q & mask_q);
    assign frame_stat = raw_q[FRAME_STAT_BIT];

endmodule

// File: rtl/lrt_axis_seq.sv
// Module: lrt_axis_seq
// One raster axis: walks sync, back porch, active and front porch, each for
// its programmed length, advancing one step per 'adv'. Held at the first sync
// step while 'run' is low. Assumes every length is at least one.
module lrt_axis_seq
    import lrt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             adv,
    input  logic [CNT_W-1:0] sync_len,
    input  logic [CNT_W-1:0] back_len,
    input  logic [CNT_W-1:0] act_len,
    input  logic [CNT_W-1:0] frnt_len,
    output lrt_phase_e       phase,
    output logic [CNT_W-1:0] pos,
    output logic             wrap,
    output logic             sync_done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    lrt_phase_e       phase_q;
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] cur_len;
    logic             at_last;

    // Length of the phase currently being counted.
    always_comb begin
        case (phase_q)
            PH_SYNC: cur_len = sync_len;
            PH_BACK: cur_len = back_len;
            PH_ACT:  cur_len = act_len;
            default: cur_len = frnt_len;
        endcase
    end

    assign at_last = (pos_q == cur_len - ONE);

    // Phase and position within phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= PH_SYNC;
            pos_q   <= '0;
        end else if (adv) begin
            if (at_last) begin
                phase_q <= lrt_phase_e'(phase_q + 2'd1);
                pos_q   <= '0;
            end else begin
                pos_q   <= pos_q + ONE;
            end
        end
    end

    assign phase     = phase_q;
    assign pos       = pos_q;
    assign wrap      = adv && at_last && (phase_q == PH_FRNT);
    assign sync_done = adv && at_last && (phase_q == PH_SYNC);

endmodule

// File: rtl/lrt_out_stage.sv
// Module: lrt_out_stage
// Turns the two axis phases into panel signals: polarity-adjusted syncs,
// data-enable, column/row and the start-of-frame strobe. Everything idles
// while 'run' is low. Purely combinational from registered state.
module lrt_out_stage
    import lrt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             run,
    input  lrt_phase_e       h_phase,
    input  logic [CNT_W-1:0] h_pos,
    input  lrt_phase_e       v_phase,
    input  logic [CNT_W-1:0] v_pos,
    input  logic             inv_h,
    input  logic             inv_v,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [CNT_W-1:0] col,
    output logic [CNT_W-1:0] row,
    output logic             sof
);
    logic h_act, v_act;

    // Decode of active region and syncs.
    always_comb begin
        h_act = run && (h_phase == PH_ACT);
        v_act = run && (v_phase == PH_ACT);
        de    = h_act && v_act;
        col   = de ? h_pos : '0;
        row   = de ? v_pos : '0;
        sof   = de && (h_pos == '0) && (v_pos == '0);
        hsync = (run && (h_phase == PH_SYNC)) ^ inv_h;
        vsync = (run && (v_phase == PH_SYNC)) ^ inv_v;
    end

endmodule

// File: rtl/lcd_raster_timing.sv
// Module: lcd_raster_timing (top)
// Register-programmed TFT raster timing generator. Decodes the packed
// timing fields into phase lengths, runs a horizontal and a vertical axis
// sequencer, and drives the panel outputs. Runs only with enable and power.
module lcd_raster_timing
    import lrt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              lcd_hsync,
    output logic              lcd_vsync,
    output logic              lcd_de,
    output logic [CNT_W-1:0]  lcd_col,
    output logic [CNT_W-1:0]  lcd_row,
    output logic              lcd_sof,
    output logic              lcd_clk_inv,
    output logic              lcd_irq
);
    localparam int N_AXES = 2;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] SIXTEEN = CNT_W'(16);

    logic [7:0] h_sync_f, h_back_f, h_frnt_f, v_back_f, v_frnt_f;
    logic [5:0] h_act_f, v_sync_f;
    logic [9:0] v_act_f;
    logic       inv_h, inv_v, en, pwr, run, frame_stat;

    logic [CNT_W-1:0] len_sync [N_AXES];
    logic [CNT_W-1:0] len_back [N_AXES];
    logic [CNT_W-1:0] len_act  [N_AXES];
    logic [CNT_W-1:0] len_frnt [N_AXES];
    logic [N_AXES-1:0] adv, wrap, sync_done;
    lrt_phase_e        phase [N_AXES];
    logic [CNT_W-1:0]  pos   [N_AXES];

    lrt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .frame_evt(sync_done[1]),
        .h_sync_f(h_sync_f), .h_back_f(h_back_f), .h_frnt_f(h_frnt_f),
        .h_act_f(h_act_f), .v_sync_f(v_sync_f), .v_back_f(v_back_f),
        .v_frnt_f(v_frnt_f), .v_act_f(v_act_f), .inv_h(inv_h), .inv_v(inv_v),
        .inv_clk(lcd_clk_inv), .en(en), .pwr(pwr), .irq(lcd_irq),
        .frame_stat(frame_stat)
    );

    assign run = en && pwr;

    // Field decode: durations are field+1, active width in 16-pixel units.
    always_comb begin
        len_sync[0] = CNT_W'(h_sync_f) + ONE;
        len_back[0] = CNT_W'(h_back_f) + ONE;
        len_act[0]  = CNT_W'({h_act_f, 4'b0000}) + SIXTEEN;
        len_frnt[0] = CNT_W'(h_frnt_f) + ONE;
        len_sync[1] = CNT_W'(v_sync_f) + ONE;
        len_back[1] = CNT_W'(v_back_f) + ONE;
        len_act[1]  = CNT_W'(v_act_f) + ONE;
        len_frnt[1] = CNT_W'(v_frnt_f) + ONE;
    end

    // Horizontal steps every clock; vertical steps when a line wraps.
    assign adv[0] = 1'b1;
    assign adv[1] = wrap[0];

    generate
        for (genvar a = 0; a < N_AXES; a++) begin : g_axis
            lrt_axis_seq #(.CNT_W(CNT_W)) seq_i (
                .clk(clk), .rst_n(rst_n), .run(run), .adv(adv[a]),
                .sync_len(len_sync[a]), .back_len(len_back[a]),
                .act_len(len_act[a]), .frnt_len(len_frnt[a]),
                .phase(phase[a]), .pos(pos[a]), .wrap(wrap[a]),
                .sync_done(sync_done[a])
            );
        end
    endgenerate

    lrt_out_stage #(.CNT_W(CNT_W)) out_i (
        .run(run), .h_phase(phase[0]), .h_pos(pos[0]),
        .v_phase(phase[1]), .v_pos(pos[1]), .inv_h(inv_h), .inv_v(inv_v),
        .hsync(lcd_hsync), .vsync(lcd_vsync), .de(lcd_de),
        .col(lcd_col), .row(lcd_row), .sof(lcd_sof)
    );

endmodule

// File: rtl/lrt_checker.sv
// Module: lrt_checker
// Temporal properties of the raster outputs, bound onto the top module.
module lrt_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             inv_h,
    input logic             inv_v,
    input logic             hsync,
    input logic             vsync,
    input logic             de,
    input logic             sof,
    input logic [CNT_W-1:0] col,
    input logic [CNT_W-1:0] row,
    input logic             frame_stat
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R10: idle outputs whenever the raster is stopped.
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!de && !sof && col == '0 && row == '0 &&
                  hsync == inv_h && vsync == inv_v));

    // R7: data-enable never overlaps a sync phase.
    a_r7_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync == inv_h && vsync == inv_v));

    // R7: column steps by one across consecutive active pixels.
    a_r7_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (de && $past(de)) |-> (col == $past(col) + ONE && row == $past(row)));

    // R8: strobe only on the first active pixel, and never two cycles in a row.
    a_r8_sof_origin: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (de && col == '0 && row == '0));
    a_r8_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

    // R11: frame status rises only right after a vertical sync cycle.
    a_r11_stat_after_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_stat) && run) |-> $past(vsync != inv_v));

endmodule

bind lcd_raster_timing lrt_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .run(run), .inv_h(inv_h), .inv_v(inv_v),
    .hsync(lcd_hsync), .vsync(lcd_vsync), .de(lcd_de), .sof(lcd_sof),
    .col(lcd_col), .row(lcd_row), .frame_stat(frame_stat)
);

// File: tb/lcd_raster_timing_tb.sv
`timescale 1ns/1ps
// Bench: register table walk, then directed raster, gating and status tests.
module lcd_raster_timing_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lcd_hsync, lcd_vsync, lcd_de, lcd_sof, lcd_clk_inv, lcd_irq;
    logic [11:0] lcd_col, lcd_row;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lcd_raster_timing dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lcd_hsync(lcd_hsync),
        .lcd_vsync(lcd_vsync), .lcd_de(lcd_de), .lcd_col(lcd_col),
        .lcd_row(lcd_row), .lcd_sof(lcd_sof), .lcd_clk_inv(lcd_clk_inv),
        .lcd_irq(lcd_irq)
    );

    // {write, offset, write data, expected read}
    localparam int NV = 26;
    localparam logic [76:0] VEC [NV] = '{
        {1'b0, 12'h000, 32'h0, 32'h0},                // R2 reset values
        {1'b0, 12'h004, 32'h0, 32'h0},
        {1'b0, 12'h008, 32'h0, 32'h0},
        {1'b0, 12'h00C, 32'h0, 32'h0},
        {1'b0, 12'h018, 32'h0, 32'h0},
        {1'b0, 12'h01C, 32'h0, 32'h0},
        {1'b0, 12'h020, 32'h0, 32'h0},
        {1'b0, 12'h024, 32'h0, 32'h0},
        {1'b0, 12'hFE0, 32'h0, 32'h11},               // R1 identification bytes
        {1'b0, 12'hFE4, 32'h0, 32'h11},
        {1'b0, 12'hFE8, 32'h0, 32'h04},
        {1'b0, 12'hFEC, 32'h0, 32'h00},
        {1'b0, 12'hFF0, 32'h0, 32'h0D},
        {1'b0, 12'hFF4, 32'h0, 32'hF0},
        {1'b0, 12'hFF8, 32'h0, 32'h05},
        {1'b0, 12'hFFC, 32'h0, 32'hB1},
        {1'b1, 12'hFE0, 32'hFF, 32'h11},              // R1 write ignored
        {1'b1, 12'hFFC, 32'h0, 32'hB1},
        {1'b1, 12'h020, 32'hFFFFFFFF, 32'h0},         // R2 raw status read-only
        {1'b1, 12'h000, 32'h12345678, 32'h12345678},  // R2 readback
        {1'b1, 12'h004, 32'h89ABCDEF, 32'h89ABCDEF},
        {1'b1, 12'h008, 32'h00003800, 32'h00003800},
        {1'b1, 12'h00C, 32'h0001007F, 32'h0001007F},
        {1'b1, 12'h01C, 32'hFFFFFFFF, 32'h0000001F},
        {1'b1, 12'h01C, 32'h0, 32'h0},
        {1'b1, 12'h028, 32'hFFFFFFFF, 32'h0}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Write lands at the next rising edge.
    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic check_idle(input string tag, input logic ih, input logic iv);
        @(negedge clk);
        check(tag, {lcd_hsync, lcd_vsync, lcd_de, lcd_sof, lcd_col, lcd_row},
                   {ih, iv, 1'b0, 1'b0, 12'd0, 12'd0});
    endtask

    // Compare raster outputs for n cycles after the start-of-raster edge (R5..R11).
    task automatic check_raster(input int hs, input int hb, input int ha, input int hf,
                                input int vs, input int vb, input int va, input int vf,
                                input logic ih, input logic iv, input bit irq_on,
                                input int n);
        int hl, fl;
        hl = hs + hb + ha + hf;
        fl = vs + vb + va + vf;
        for (int t = 0; t < n; t++) begin
            int hp, ln, ec, er;
            logic hsa, vsa, hac, vac, de_e, sof_e, irq_e;
            @(negedge clk);
            hp = t % hl;
            ln = (t / hl) % fl;
            hsa = hp < hs;
            vsa = ln < vs;
            hac = (hp >= hs + hb) && (hp < hs + hb + ha);
            vac = (ln >= vs + vb) && (ln < vs + vb + va);
            de_e = hac && vac;
            ec = de_e ? hp - hs - hb : 0;
            er = de_e ? ln - vs - vb : 0;
            sof_e = de_e && ec == 0 && er == 0;
            irq_e = irq_on && (t >= hl * vs);
            check("R5/R6/R7/R8/R9/R11 raster",
                  {lcd_hsync, lcd_vsync, lcd_de, lcd_sof, lcd_irq, lcd_col, lcd_row},
                  {hsa ^ ih, vsa ^ iv, de_e, sof_e, irq_e, ec[11:0], er[11:0]});
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state: idle outputs, no interrupt.
        check_idle("R10 reset idle", 1'b0, 1'b0);
        check("R11 reset irq", 64'(lcd_irq), 64'd0);

        // Register table walk (R1, R2).
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) wr_reg(VEC[i][75:64], VEC[i][63:32]);
            rd_reg(VEC[i][75:64], d);
            check("R1/R2 register table", 64'(d), 64'(VEC[i][31:0]));
        end
        check("R9 clk invert select", 64'(lcd_clk_inv), 64'd1);

        // Pattern 1: H = 2+2+16+2 = 22, V = 1+1+2+1 = 5 lines, mask frame bit.
        wr_reg(12'h000, 32'h01010100);
        wr_reg(12'h004, 32'h00000001);
        wr_reg(12'h008, 32'h0);
        wr_reg(12'h01C, 32'h8);
        // R4: power without prior enable is dropped.
        wr_reg(12'h018, 32'h800);
        rd_reg(12'h018, d);
        check("R4 power needs enable first", 64'(d), 64'h0);
        check_idle("R10 idle power only", 1'b0, 1'b0);
        // R4: enable and power in one write keeps power off.
        wr_reg(12'h018, 32'h801);
        rd_reg(12'h018, d);
        check("R4 single write power dropped", 64'(d), 64'h1);
        check_idle("R10 idle enable only", 1'b0, 1'b0);
        // R3: timing write ignored while enabled.
        wr_reg(12'h000, 32'hFFFFFFFF);
        rd_reg(12'h000, d);
        check("R3 timing frozen", 64'(d), 64'h01010100);
        // Start raster; first cycle after this edge is sync clock 0 of line 0.
        wr_reg(12'h018, 32'h801);
        check_raster(2, 2, 16, 2, 1, 1, 2, 1, 1'b0, 1'b0, 1'b1, 140);
        rd_reg(12'h024, d);
        check("R11 masked status", 64'(d), 64'h8);

        // R10: stop; outputs idle in the next cycle.
        wr_reg(12'h018, 32'h0);
        check_idle("R10 stop idle", 1'b0, 1'b0);
        // R11: write-one-to-clear.
        wr_reg(12'h028, 32'h8);
        rd_reg(12'h020, d);
        check("R11 clear raw", 64'(d), 64'h0);
        check("R11 irq dropped", 64'(lcd_irq), 64'd0);

        // Pattern 2: inverted syncs, H = 1+3+32+1 = 37, V = 2+2+1+2 = 7, no mask.
        wr_reg(12'h000, 32'h02000004);
        wr_reg(12'h004, 32'h01010400);
        wr_reg(12'h008, 32'h00003800);
        wr_reg(12'h01C, 32'h0);
        check_idle("R9/R10 inverted idle", 1'b1, 1'b1);
        wr_reg(12'h018, 32'h1);
        wr_reg(12'h018, 32'h801);
        check_raster(1, 3, 32, 1, 2, 2, 1, 2, 1'b1, 1'b1, 1'b0, 280);
        rd_reg(12'h020, d);
        check("R11 raw set once per frame", 64'(d), 64'h8);
        rd_reg(12'h024, d);
        check("R11 masked off", 64'(d), 64'h0);

        // R10: restart after stop begins at sync of line 0 again.
        wr_reg(12'h018, 32'h0);
        wr_reg(12'h018, 32'h1);
        wr_reg(12'h018, 32'h801);
        check_raster(1, 3, 32, 1, 2, 2, 1, 2, 1'b1, 1'b1, 1'b0, 100);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule